// File: doc/BRIEF.md
# Memory activate throttling controller

This block caps how many DRAM row activates a memory controller may issue inside a fixed-length throttling window. Every cycle, the scheduler presents an activate request and is allowed to issue it only while `act_ok` is high. The block counts the activates that actually issue in the current window. When that count goes past a programmed global ceiling, the block enters a throttled period. That period stays in force for the rest of the window and then for sixteen further full windows.

While throttled, each window may issue only as many activates as the active limit allows. The source of that limit depends on a loop-select control bit. In the open-loop regime the limit is the low-limit register, and temperature plays no part. In the closed-loop regime the limit follows a temperature-zone input. A mode bit chooses between two responses to heat. One is a single-step jump to the mid or low limit. The other is a staircase that takes one off the previous limit at every window boundary, with the low limit as its floor.

The limit registers are written through a simple write port. Each accepted write makes the block busy for a fixed number of cycles. A write that arrives while the block is busy is dropped and sets a sticky error flag.

Top module: `act_throttle`

## Requirements
- R1: The window counter runs freely from reset with a period of WIN_LEN cycles (default 32). The count of issued activates (request high while `act_ok` is high) is cleared at every window end. In the cycle after an issued activate takes the window's count above the global limit, `gthrot` is 1.
- R2: Once `gthrot` rises, it falls only at a window end. It stays high for the rest of the triggering window and then for exactly 16 further full windows. Register writes made during that time do not shorten it.
- R3: While `gthrot` is 0, `act_ok` is 1. While `gthrot` is 1, `act_ok` is 0 from the point where the window's issued count equals the active limit until the window ends.
- R4: With control bit 0 (loop select) at 0, the active limit is the low-limit register and `temp_zone` is ignored. A write to the low limit changes the allowance from the next cycle, inside the current window.
- R5: With control bit 0 at 1 and control bit 1 (mode) at 1, the active limit is the single-step choice. Zone 0 selects the high limit, zone 1 the mid limit, and zones 2 and 3 the low limit. The choice takes effect from the cycle after the zone changes.
- R6: With control bit 0 at 1 and control bit 1 at 0 (staircase), zone 0 reloads the high limit each cycle. In any other zone, the limit becomes the previous limit minus one at each window end and is never less than the low limit.
- R7: A write with `cfg_we` high and `cfg_busy` low is accepted. `cfg_sel` 0 selects the global limit, 1 the low limit, 2 the mid limit, 3 the high limit, and 4 the control bits from `cfg_wdata[1:0]`. The written value applies from the next cycle, and `cfg_busy` is 1 for exactly 40 cycles after the accepting edge.
- R8: A write that arrives while `cfg_busy` is 1 changes no register and sets `cfg_err`. `cfg_err` then stays at 1 until reset.
- R9: After reset, `act_ok`=1, `gthrot`=0, `cfg_busy`=0 and `cfg_err`=0. The reset values are global limit 16, low 4, mid 8 and high 12, with open loop and staircase mode selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| act_req | input | 1 | Scheduler wants to issue an activate this cycle |
| temp_zone | input | 2 | Temperature zone: 0 cool, 1 past mid threshold, 2-3 hotter |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select for the write |
| cfg_wdata | input | 8 | Write data |
| act_ok | output | 1 | Activate may issue this cycle |
| gthrot | output | 1 | Global throttled period in force |
| cfg_busy | output | 1 | A register update is still completing |
| cfg_err | output | 1 | Sticky flag: a write arrived while busy |

## Verification
`act_ok` depends combinationally on registered state. It reacts one cycle after the activate that reaches the limit and one cycle after a low-limit or zone change. `gthrot` rises one cycle after the activate that goes past the limit, and it falls only on the edge that ends a window. The bench keeps its own cycle count, mirrored from reset, so it knows each window's slot. It drives and samples at the falling edge, so every expectation is placed at a known slot. Busy and error are checked at exact edge counts after the accepting write. The staircase is checked window by window, one step per boundary.

// File: rtl/act_throttle_pkg.sv
package act_throttle_pkg;

    localparam int LIM_W = 8;

    typedef logic [LIM_W-1:0] lim_t;

    typedef enum logic [2:0] {
        SEL_GLOBAL = 3'd0,
        SEL_LOW    = 3'd1,
        SEL_MID    = 3'd2,
        SEL_HIGH   = 3'd3,
        SEL_CTRL   = 3'd4
    } cfg_sel_e;

    typedef enum logic [1:0] {
        ZONE_COOL = 2'd0,
        ZONE_WARM = 2'd1,
        ZONE_HOT  = 2'd2,
        ZONE_CRIT = 2'd3
    } zone_e;

    typedef struct packed {
        lim_t glim;
        lim_t lo;
        lim_t mid;
        lim_t hi;
        logic closed;   // 1: temperature-driven limit
        logic single;   // 1: single-step, 0: staircase
    } thr_cfg_t;

    // one staircase step, floored at the low limit
    function automatic lim_t stair_next(lim_t cur, lim_t floor_v);
        if (cur > floor_v)
            return cur - lim_t'(1);
        return floor_v;
    endfunction

    function automatic lim_t single_pick(zone_e z, lim_t lo, lim_t mid, lim_t hi);
        case (z)
            ZONE_COOL: return hi;
            ZONE_WARM: return mid;
            default:   return lo;
        endcase
    endfunction

endpackage

// File: rtl/act_cfg.sv
module act_cfg
    import act_throttle_pkg::*;
#(
    parameter int   BUSY_CYCLES = 40,
    parameter lim_t GLIM_RST    = 8'd16,
    parameter lim_t LO_RST      = 8'd4,
    parameter lim_t MID_RST     = 8'd8,
    parameter lim_t HI_RST      = 8'd12
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  logic [2:0] sel,
    input  lim_t     wdata,
    output thr_cfg_t cfg,
    output logic     busy,
    output logic     err
);
    localparam int BW = $clog2(BUSY_CYCLES + 1);

    logic [BW-1:0] bcnt;
    logic          accept;

    assign busy   = (bcnt != '0);
    assign accept = we && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.glim   <= GLIM_RST;
            cfg.lo     <= LO_RST;
            cfg.mid    <= MID_RST;
            cfg.hi     <= HI_RST;
            cfg.closed <= 1'b0;
            cfg.single <= 1'b0;
            bcnt       <= '0;
            err        <= 1'b0;
        end else begin
            if (accept) begin
                bcnt <= BW'(BUSY_CYCLES);
                case (cfg_sel_e'(sel))
                    SEL_GLOBAL: cfg.glim <= wdata;
                    SEL_LOW:    cfg.lo   <= wdata;
                    SEL_MID:    cfg.mid  <= wdata;
                    SEL_HIGH:   cfg.hi   <= wdata;
                    SEL_CTRL: begin
                        cfg.closed <= wdata[0];
                        cfg.single <= wdata[1];
                    end
                    default: ;
                endcase
            end else if (busy) begin
                bcnt <= bcnt - 1'b1;
            end
            if (we && busy)
                err <= 1'b1;
        end
    end

    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (we && !busy) |=> busy);

    // R8
    reject_err_chk: assert property (@(posedge clk) disable iff (rst)
        (we && busy) |=> err);

    // R8
    reject_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (we && busy) |=> $stable(cfg));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

endmodule

// File: rtl/act_limit.sv
module act_limit
    import act_throttle_pkg::*;
#(
    parameter lim_t HI_RST = 8'd12
) (
    input  logic  clk,
    input  logic  rst,
    input  zone_e zone,
    input  logic  win_end,
    input  lim_t  lo,
    input  lim_t  mid,
    input  lim_t  hi,
    input  logic  closed,
    input  logic  single,
    output lim_t  act_lim
);
    lim_t cl_lim;

    always_ff @(posedge clk) begin
        if (rst)
            cl_lim <= HI_RST;
        else if (zone == ZONE_COOL)
            cl_lim <= hi;
        else if (single)
            cl_lim <= single_pick(zone, lo, mid, hi);
        else if (win_end)
            cl_lim <= stair_next(cl_lim, lo);
    end

    assign act_lim = closed ? cl_lim : lo;

    // R6
    stair_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (zone != ZONE_COOL && !single && !win_end) |=> $stable(cl_lim));

    // R6
    stair_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (zone != ZONE_COOL && !single && win_end) |=> (cl_lim >= $past(lo)));

    // R5
    single_mid_chk: assert property (@(posedge clk) disable iff (rst)
        (zone == ZONE_WARM && single) |=> (cl_lim == $past(mid)));

endmodule

// File: rtl/act_window.sv
module act_window
    import act_throttle_pkg::*;
#(
    parameter int WIN_LEN      = 32,
    parameter int HOLD_WINDOWS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic act_req,
    input  lim_t glim,
    input  lim_t act_lim,
    output logic act_ok,
    output logic gthrot,
    output logic win_end
);
    localparam int WW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam int HW = $clog2(HOLD_WINDOWS + 2);

    logic [WW-1:0]  wcnt;
    logic [HW-1:0]  hold;
    lim_t           acnt;
    logic [LIM_W:0] cnt_nxt;
    logic           issue;
    logic           trig;

    assign win_end = (wcnt == WW'(WIN_LEN - 1));
    assign act_ok  = !gthrot || (acnt < act_lim);
    assign issue   = act_req && act_ok;
    assign cnt_nxt = {1'b0, acnt} + (LIM_W + 1)'(issue);
    assign trig    = !gthrot && (cnt_nxt > {1'b0, glim});

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt   <= '0;
            acnt   <= '0;
            hold   <= '0;
            gthrot <= 1'b0;
        end else begin
            wcnt <= win_end ? '0 : wcnt + 1'b1;
            if (win_end)
                acnt <= '0;
            else if (cnt_nxt[LIM_W])
                acnt <= '1;
            else
                acnt <= cnt_nxt[LIM_W-1:0];

            if (trig) begin
                gthrot <= 1'b1;
                hold   <= win_end ? HW'(HOLD_WINDOWS) : HW'(HOLD_WINDOWS + 1);
            end else if (gthrot && win_end) begin
                hold <= hold - 1'b1;
                if (hold == HW'(1))
                    gthrot <= 1'b0;
            end
        end
    end

    // R1
    rise_after_issue_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gthrot) |-> $past(issue));

    // R2
    hold_mid_window_chk: assert property (@(posedge clk) disable iff (rst)
        (gthrot && !win_end) |=> gthrot);

    // R2
    hold_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        gthrot |-> (hold != '0));

    // R3
    block_persist_chk: assert property (@(posedge clk) disable iff (rst)
        (gthrot && !act_ok && !win_end) |=> (!act_ok || act_lim != $past(act_lim)));

endmodule

// File: rtl/act_throttle.sv
module act_throttle
    import act_throttle_pkg::*;
#(
    parameter int   WIN_LEN      = 32,
    parameter int   HOLD_WINDOWS = 16,
    parameter int   BUSY_CYCLES  = 40,
    parameter lim_t GLIM_RST     = 8'd16,
    parameter lim_t LO_RST       = 8'd4,
    parameter lim_t MID_RST      = 8'd8,
    parameter lim_t HI_RST       = 8'd12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_req,
    input  logic [1:0]       temp_zone,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_sel,
    input  logic [LIM_W-1:0] cfg_wdata,
    output logic             act_ok,
    output logic             gthrot,
    output logic             cfg_busy,
    output logic             cfg_err
);
    thr_cfg_t cfg;
    lim_t     act_lim;
    logic     win_end;

    act_cfg #(
        .BUSY_CYCLES(BUSY_CYCLES),
        .GLIM_RST(GLIM_RST),
        .LO_RST(LO_RST),
        .MID_RST(MID_RST),
        .HI_RST(HI_RST)
    ) u_cfg (
        .clk(clk),
        .rst(rst),
        .we(cfg_we),
        .sel(cfg_sel),
        .wdata(cfg_wdata),
        .cfg(cfg),
        .busy(cfg_busy),
        .err(cfg_err)
    );

    act_limit #(
        .HI_RST(HI_RST)
    ) u_limit (
        .clk(clk),
        .rst(rst),
        .zone(zone_e'(temp_zone)),
        .win_end(win_end),
        .lo(cfg.lo),
        .mid(cfg.mid),
        .hi(cfg.hi),
        .closed(cfg.closed),
        .single(cfg.single),
        .act_lim(act_lim)
    );

    act_window #(
        .WIN_LEN(WIN_LEN),
        .HOLD_WINDOWS(HOLD_WINDOWS)
    ) u_window (
        .clk(clk),
        .rst(rst),
        .act_req(act_req),
        .glim(cfg.glim),
        .act_lim(act_lim),
        .act_ok(act_ok),
        .gthrot(gthrot),
        .win_end(win_end)
    );

endmodule

// File: tb/act_throttle_bench.sv
`timescale 1ns/1ps
module act_throttle_bench;
    localparam int WIN = 32;

    // table entry: [11] loop select, [10] mode, [9:8] zone, [7:0] expected grants
    localparam logic [11:0] TBL [6] = '{
        {1'b0, 1'b0, 2'd0, 8'd2},
        {1'b0, 1'b1, 2'd2, 8'd2},
        {1'b1, 1'b1, 2'd0, 8'd6},
        {1'b1, 1'b1, 2'd1, 8'd4},
        {1'b1, 1'b1, 2'd2, 8'd2},
        {1'b1, 1'b1, 2'd3, 8'd2}
    };
    localparam int STAIR_EXP [6] = '{6, 5, 4, 3, 2, 2};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       act_req = 1'b0;
    logic [1:0] temp_zone = 2'd0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_sel = 3'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic       act_ok, gthrot, cfg_busy, cfg_err;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    act_throttle u_act_throttle (
        .clk(clk), .rst(rst), .act_req(act_req), .temp_zone(temp_zone),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .act_ok(act_ok), .gthrot(gthrot), .cfg_busy(cfg_busy), .cfg_err(cfg_err)
    );

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(logic [2:0] sel, logic [7:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr(logic [2:0] sel, logic [7:0] data);
        cfg_write(sel, data);
        repeat (40) @(negedge clk);
    endtask

    task automatic to_slot(int s);
        while (cyc % WIN != s) @(negedge clk);
    endtask

    task automatic run_win(int nreq, output int got);
        got = 0;
        for (int i = 0; i < WIN; i++) begin
            act_req = (i < nreq);
            #1;
            if (act_req && act_ok) got++;
            @(negedge clk);
        end
        act_req = 1'b0;
    endtask

    task automatic trigger_if_idle();
        if (!gthrot) begin
            act_req = 1'b1;
            @(negedge clk);
            act_req = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int got;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        chk("R9 act_ok", act_ok, 1);
        chk("R9 gthrot", gthrot, 0);
        chk("R9 cfg_busy", cfg_busy, 0);
        chk("R9 cfg_err", cfg_err, 0);

        // R7 busy window, R8 rejected write
        cfg_write(3'd0, 8'd3);
        chk("R7 busy after write", cfg_busy, 1);
        cfg_write(3'd0, 8'd9);
        chk("R8 err set", cfg_err, 1);
        repeat (38) @(negedge clk);
        chk("R7 busy at cycle 40", cfg_busy, 1);
        @(negedge clk);
        chk("R7 busy cleared after 40", cfg_busy, 0);

        // R1 with limit 3: exactly 3 activates do not trigger
        to_slot(0);
        run_win(3, got);
        chk("R1 grants below trigger", got, 3);
        chk("R8 ignored write kept limit 3 (no trigger)", gthrot, 0);

        // R1 fourth activate triggers
        for (int i = 0; i < 4; i++) begin
            act_req = 1'b1;
            if (i == 3) chk("R1 not yet throttled", gthrot, 0);
            @(negedge clk);
        end
        act_req = 1'b0;
        chk("R1 throttle one cycle after exceeding", gthrot, 1);

        // W1: open-loop default low limit 4
        to_slot(0);
        run_win(10, got);
        chk("R3 throttled grants equal low limit", got, 4);
        // W2: write during hold
        cfg_write(3'd0, 8'd200);
        to_slot(0);
        // W3: low-limit write takes effect inside window
        got = 0;
        for (int i = 0; i < WIN; i++) begin
            act_req = (i < 10) || (i >= 13 && i < 21);
            if (i == 12) begin
                chk("R3 blocked after limit", act_ok, 0);
                cfg_we = 1'b1; cfg_sel = 3'd1; cfg_wdata = 8'd7;
            end
            if (i == 13) cfg_we = 1'b0;
            #1;
            if (act_req && act_ok) got++;
            @(negedge clk);
        end
        act_req = 1'b0;
        chk("R4 low write applies in same window", got, 7);
        // W4 -> W16
        repeat (12 * WIN) @(negedge clk);
        chk("R2 still throttled in 16th window", gthrot, 1);
        repeat (WIN) @(negedge clk);
        chk("R2 released after 16 windows", gthrot, 0);
        run_win(10, got);
        chk("R3 unthrottled grants all", got, 10);
        chk("R1 limit 200 not exceeded", gthrot, 0);

        // table setup
        wr(3'd1, 8'd2);
        wr(3'd2, 8'd4);
        wr(3'd3, 8'd6);
        wr(3'd0, 8'd0);
        for (int k = 0; k < 6; k++) begin
            temp_zone = TBL[k][9:8];
            wr(3'd4, {6'd0, TBL[k][10], TBL[k][11]});
            trigger_if_idle();
            to_slot(0);
            chk("R1 throttle active for table window", gthrot, 1);
            run_win(10, got);
            if (k < 2) chk("R4 open-loop limit", got, int'(TBL[k][7:0]));
            else       chk("R5 single-step limit", got, int'(TBL[k][7:0]));
        end

        // R6 staircase
        temp_zone = 2'd0;
        wr(3'd4, 8'd1);
        while (gthrot) @(negedge clk);
        trigger_if_idle();
        to_slot(0);
        temp_zone = 2'd1;
        for (int k = 0; k < 6; k++) begin
            run_win(10, got);
            chk("R6 staircase step", got, STAIR_EXP[k]);
        end
        temp_zone = 2'd0;
        run_win(10, got);
        chk("R6 cool zone reloads high", got, 6);
        chk("R8 err still sticky", cfg_err, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule